// File: doc/BRIEF.md
# Digital Pulse Trigger with Bipolar Timing Filter

This block finds detector pulses in a stream of signed 14-bit ADC samples, taking one sample on every clock. It issues exactly one trigger per accepted pulse. The samples first pass through a running mean over a power-of-two window, which suppresses high-frequency noise. A discrete derivative of first order (CR) or second order (CR²) then removes the baseline and turns each unipolar pulse into a bipolar shape. The filtered stream goes to a monitoring output.

The filtered value must reach a programmable threshold before a trigger is possible. Reaching the threshold only arms the block. The trigger itself is produced when the filtered signal next falls to zero or below. An optional time-over-threshold rule rejects pulses whose filtered value stays at or above the threshold for too few samples. On every trigger the block captures a free-running sample-clock counter, which gives the event time with one sample period of uncertainty. A software request and an external request can be merged with the self-trigger, and an enable mask selects which of the three sources may fire.

The self-trigger controller has four states:
- **IDLE**: waiting for the filtered value to reach the threshold (IDLE→ARMED).
- **ARMED**: counting samples at or above the threshold. It leaves ARMED in one of three ways:
  - ARMED→HOLD, firing, when the value drops to zero or below and the pulse qualifies.
  - ARMED→WAIT_ZC when the value drops between zero and the threshold and the pulse qualifies.
  - ARMED→IDLE, rejecting the pulse, when it does not qualify.
- **WAIT_ZC**: waiting for the zero crossing (WAIT_ZC→HOLD, firing).
- **HOLD**: disarmed until the value is below the threshold (HOLD→IDLE).

Top module: `pulse_trig_top`

## Requirements
- R1: While reset is held and right after it, trig_o is 0, tstamp_o is 0 and filt_o is 0.
- R2: The mean m(u) is the floor of the sum of the last 2^A samples divided by 2^A, where A = cfg_avg_log. Values of A above 5 act as 5. Samples from before reset count as zero.
- R3: With B = 2^cfg_span_log (values above 5 act as 5), define D(u) = m(u) − m(u−B). When cfg_order=0, F(u) = D(u). When cfg_order=1, F(u) = D(u) − D(u−B). If the sample captured at clock edge n is x(n), then filt_o after edge n shows F(n−2). Edges are counted from 1 after reset release.
- R4: filt_o is DW+2 bits wide and stays exact for full-scale alternating 14-bit input in CR² mode with A=0 and B=1.
- R5: The controller moves from IDLE to ARMED at the edge where the filt_o value presented to it is at or above cfg_thresh (signed). cfg_thresh must be positive.
- R6: In ARMED or WAIT_ZC, a presented value at or below zero fires the self-trigger. trig_o is then high for the cycle after the one in which filt_o showed that value.
- R7: With cfg_tot_en=1, a pulse fires only if at least cfg_tot_min consecutive presented values were at or above the threshold. A rejected pulse returns to IDLE without a trigger.
- R8: After a self-trigger the controller stays in HOLD until a presented value is below the threshold, so one pulse never fires twice.
- R9: When trig_o is high after edge n, tstamp_o holds n−1. This is the free-running counter value before that edge, and tstamp_o keeps it until the next trigger.
- R10: cfg_src_en bit 0 enables the self-trigger, bit 1 enables sw_trig_i and bit 2 enables ext_trig_i. An enabled request sampled at edge n makes trig_o high for the cycle after edge n. Requests that coincide give a single pulse. A disabled source has no effect on trig_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | DW | Signed ADC sample, one per clock |
| cfg_avg_log | input | 3 | log2 of the mean window |
| cfg_span_log | input | 3 | log2 of the derivative span |
| cfg_order | input | 1 | 0 = first-order derivative, 1 = second-order |
| cfg_thresh | input | DW+2 | Signed arming threshold |
| cfg_tot_en | input | 1 | Enable the time-over-threshold qualification |
| cfg_tot_min | input | CW | Minimum number of samples at or above the threshold |
| cfg_src_en | input | 3 | Trigger source enables (self, software, external) |
| sw_trig_i | input | 1 | Software trigger request |
| ext_trig_i | input | 1 | External trigger request |
| trig_o | output | 1 | Trigger pulse |
| tstamp_o | output | TSW | Timestamp captured on the last trigger |
| filt_o | output | DW+2 | Filtered bipolar stream |

## Verification
The bench compares filt_o every cycle against a model of the mean and the derivative. An off-by-one in the delay taps, or a wrong window or span index, would shift or distort every value after the first pulse. The bench also drives full-scale alternating input through the second-order path with the shortest window and span. A design without enough guard bits would wrap this stream to the wrong sign.

Narrow pulses are run with a large and a small time-over-threshold minimum. A counter that was off by one or ignored would give a spurious trigger or a missed one. Coinciding and disabled sources check that triggers merge into one pulse and that masks are obeyed. Oversized window and span settings check the clamping. On each trigger the timestamp is checked against the edge count, which exposes a capture taken after the counter had already advanced.

// File: rtl/ptrig_pkg.sv
`timescale 1ns/1ps
package ptrig_pkg;

    typedef enum logic [1:0] {
        PT_IDLE    = 2'd0,
        PT_ARMED   = 2'd1,
        PT_WAIT_ZC = 2'd2,
        PT_HOLD    = 2'd3
    } ptrig_state_e;

    localparam int SRC_SELF = 0;
    localparam int SRC_SW   = 1;
    localparam int SRC_EXT  = 2;

    // limit a log2 setting to the largest supported window
    function automatic logic [2:0] pt_clamp_log(input logic [2:0] l, input int maxl);
        return (int'(l) > maxl) ? 3'(maxl) : l;
    endfunction

endpackage

// File: rtl/ptrig_mavg.sv
`timescale 1ns/1ps
module ptrig_mavg #(
    parameter int DW     = 14,
    parameter int MAXLOG = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] x_i,
    input  logic [2:0]           log_i,
    output logic signed [DW-1:0] mean_o
);
    import ptrig_pkg::*;

    localparam int DEPTH = 1 << MAXLOG;
    localparam int SW    = DW + MAXLOG;
    localparam int IW    = (MAXLOG > 0) ? MAXLOG : 1;

    logic signed [DW-1:0] hist_q [DEPTH];
    logic signed [SW-1:0] sum_q;
    logic [2:0]           eff;
    logic [IW-1:0]        idx;

    always_comb begin
        eff = pt_clamp_log(log_i, MAXLOG);
        idx = IW'((1 << eff) - 1);
    end

    // running sum: add the newest sample, drop the one leaving the window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
        end else begin
            sum_q     <= sum_q + SW'(x_i) - SW'(hist_q[idx]);
            hist_q[0] <= x_i;
            for (int i = DEPTH - 1; i > 0; i--) hist_q[i] <= hist_q[i-1];
        end
    end

    assign mean_o = DW'(sum_q >>> eff);

endmodule

// File: rtl/ptrig_deriv.sv
`timescale 1ns/1ps
module ptrig_deriv #(
    parameter int DW     = 14,
    parameter int MAXLOG = 5,
    parameter int FW     = DW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] mean_i,
    input  logic [2:0]           log_i,
    input  logic                 order_i,
    output logic signed [FW-1:0] filt_o
);
    import ptrig_pkg::*;

    localparam int DEPTH = 1 << MAXLOG;
    localparam int IW    = (MAXLOG > 0) ? MAXLOG : 1;

    logic signed [DW-1:0] mhist_q  [DEPTH];
    logic signed [DW:0]   d1hist_q [DEPTH];
    logic signed [DW:0]   d1_q;
    logic signed [FW-1:0] filt_q;
    logic [2:0]           eff;
    logic [IW-1:0]        idx;

    always_comb begin
        eff = pt_clamp_log(log_i, MAXLOG);
        idx = IW'((1 << eff) - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d1_q   <= '0;
            filt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mhist_q[i]  <= '0;
                d1hist_q[i] <= '0;
            end
        end else begin
            d1_q        <= (DW+1)'(mean_i) - (DW+1)'(mhist_q[idx]);
            mhist_q[0]  <= mean_i;
            d1hist_q[0] <= d1_q;
            for (int i = DEPTH - 1; i > 0; i--) begin
                mhist_q[i]  <= mhist_q[i-1];
                d1hist_q[i] <= d1hist_q[i-1];
            end
            if (order_i) filt_q <= FW'(d1_q) - FW'(d1hist_q[idx]);
            else         filt_q <= FW'(d1_q);
        end
    end

    assign filt_o = filt_q;

endmodule

// File: rtl/ptrig_fsm.sv
`timescale 1ns/1ps
module ptrig_fsm #(
    parameter int FW  = 16,
    parameter int CW  = 8,
    parameter int TSW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [FW-1:0] filt_i,
    input  logic signed [FW-1:0] thr_i,
    input  logic                 tot_en_i,
    input  logic [CW-1:0]        tot_min_i,
    input  logic [2:0]           src_en_i,
    input  logic                 sw_i,
    input  logic                 ext_i,
    output logic                 trig_o,
    output logic [TSW-1:0]       tstamp_o
);
    import ptrig_pkg::*;

    localparam logic [CW-1:0] CNT_MAX = '1;

    ptrig_state_e   state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic [TSW-1:0] ts_q, tstamp_q;
    logic           trig_q, trig_d;
    logic           ge_thr, le_zero, qualified, self_fire;

    always_comb begin
        ge_thr    = (filt_i >= thr_i);
        le_zero   = (filt_i <= 0);
        qualified = !tot_en_i || (cnt_q >= tot_min_i);
        state_d   = state_q;
        self_fire = 1'b0;
        unique case (state_q)
            PT_IDLE: begin
                if (ge_thr) state_d = PT_ARMED;
            end
            PT_ARMED: begin
                if (ge_thr) begin
                    state_d = PT_ARMED;
                end else if (le_zero) begin
                    self_fire = qualified;
                    state_d   = qualified ? PT_HOLD : PT_IDLE;
                end else begin
                    state_d   = qualified ? PT_WAIT_ZC : PT_IDLE;
                end
            end
            PT_WAIT_ZC: begin
                if (le_zero) begin
                    self_fire = 1'b1;
                    state_d   = PT_HOLD;
                end
            end
            PT_HOLD: begin
                if (!ge_thr) state_d = PT_IDLE;
            end
        endcase
        trig_d = (self_fire && src_en_i[SRC_SELF])
              || (sw_i      && src_en_i[SRC_SW])
              || (ext_i     && src_en_i[SRC_EXT]);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PT_IDLE;
        else        state_q <= state_d;
    end

    // outputs, time-over-threshold counter and free-running timestamp
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            ts_q     <= '0;
            tstamp_q <= '0;
            trig_q   <= 1'b0;
        end else begin
            ts_q   <= ts_q + TSW'(1);
            trig_q <= trig_d;
            if (trig_d) tstamp_q <= ts_q;
            if (state_q == PT_IDLE && ge_thr)
                cnt_q <= CW'(1);
            else if (state_q == PT_ARMED && ge_thr && cnt_q != CNT_MAX)
                cnt_q <= cnt_q + CW'(1);
        end
    end

    assign trig_o   = trig_q;
    assign tstamp_o = tstamp_q;

    // R5
    thr_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PT_ARMED && $past(state_q) == PT_IDLE) |-> $past(filt_i >= thr_i));
    // R6
    zero_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        self_fire |-> (filt_i <= 0));
    // R7
    tot_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (self_fire && tot_en_i) |-> (cnt_q >= tot_min_i));
    // R9
    tstamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (tstamp_o == ts_q - TSW'(1)));
    // R10
    src_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en_i == 3'b000) |=> !trig_o);

endmodule

// File: rtl/pulse_trig_top.sv
`timescale 1ns/1ps
module pulse_trig_top #(
    parameter int DW     = 14,
    parameter int MAXLOG = 5,
    parameter int CW     = 8,
    parameter int TSW    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] sample_i,
    input  logic [2:0]           cfg_avg_log,
    input  logic [2:0]           cfg_span_log,
    input  logic                 cfg_order,
    input  logic signed [DW+1:0] cfg_thresh,
    input  logic                 cfg_tot_en,
    input  logic [CW-1:0]        cfg_tot_min,
    input  logic [2:0]           cfg_src_en,
    input  logic                 sw_trig_i,
    input  logic                 ext_trig_i,
    output logic                 trig_o,
    output logic [TSW-1:0]       tstamp_o,
    output logic signed [DW+1:0] filt_o
);
    localparam int FW = DW + 2;

    logic signed [DW-1:0] mean_w;
    logic signed [FW-1:0] filt_w;

    ptrig_mavg #(.DW(DW), .MAXLOG(MAXLOG)) u_mavg (
        .clk    (clk),
        .rst_n  (rst_n),
        .x_i    (sample_i),
        .log_i  (cfg_avg_log),
        .mean_o (mean_w)
    );

    ptrig_deriv #(.DW(DW), .MAXLOG(MAXLOG), .FW(FW)) u_deriv (
        .clk     (clk),
        .rst_n   (rst_n),
        .mean_i  (mean_w),
        .log_i   (cfg_span_log),
        .order_i (cfg_order),
        .filt_o  (filt_w)
    );

    ptrig_fsm #(.FW(FW), .CW(CW), .TSW(TSW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .filt_i    (filt_w),
        .thr_i     (cfg_thresh),
        .tot_en_i  (cfg_tot_en),
        .tot_min_i (cfg_tot_min),
        .src_en_i  (cfg_src_en),
        .sw_i      (sw_trig_i),
        .ext_i     (ext_trig_i),
        .trig_o    (trig_o),
        .tstamp_o  (tstamp_o)
    );

    assign filt_o = filt_w;

endmodule

// File: tb/pulse_trig_top_tb_top.sv
`timescale 1ns/1ps
module pulse_trig_top_tb_top;

    localparam int MAXN = 512;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [13:0] sample_i = '0;
    logic [2:0]         c_avg = '0, c_span = '0;
    logic               c_order = 1'b0;
    logic signed [15:0] c_thr = '0;
    logic               c_tot_en = 1'b0;
    logic [7:0]         c_tot_min = '0;
    logic [2:0]         c_en = '0;
    logic               sw_trig = 1'b0, ext_trig = 1'b0;
    logic               trig_o;
    logic [31:0]        tstamp_o;
    logic signed [15:0] filt_o;

    pulse_trig_top dut_i (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
        .cfg_avg_log(c_avg), .cfg_span_log(c_span), .cfg_order(c_order),
        .cfg_thresh(c_thr), .cfg_tot_en(c_tot_en), .cfg_tot_min(c_tot_min),
        .cfg_src_en(c_en), .sw_trig_i(sw_trig), .ext_trig_i(ext_trig),
        .trig_o(trig_o), .tstamp_o(tstamp_o), .filt_o(filt_o)
    );

    always #2.5 clk = ~clk;

    typedef struct { int ed; int ts; } exp_t;
    exp_t  q[$];
    int    checks = 0, errors = 0;
    int    edge_n = 0;
    bit    mon_on = 1'b0;
    string ftag = "", ttag = "";
    int    xs [0:MAXN-1];
    int    swv [0:MAXN-1];
    int    exv [0:MAXN-1];
    int    mm [0:MAXN-1];
    int    dd [0:MAXN-1];
    int    ff [0:MAXN-1];
    int    fexp [0:MAXN-1];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) edge_n <= 0;
        else        edge_n <= edge_n + 1;
    end

    // monitor: compares the filtered stream and pops expected triggers
    always @(negedge clk) begin
        if (mon_on) begin
            chk(int'(filt_o) == fexp[edge_n], ftag, "filt_o", int'(filt_o), fexp[edge_n]);
            while (q.size() > 0 && q[0].ed < edge_n) begin
                chk(1'b0, ttag, "missed trigger at edge", 0, q[0].ed);
                void'(q.pop_front());
            end
            if (trig_o) begin
                if (q.size() == 0) begin
                    chk(1'b0, ttag, "unexpected trigger at edge", edge_n, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.ed == edge_n, ttag, "trigger edge", edge_n, e.ed);
                    chk(int'(tstamp_o) == e.ts, "R9", "tstamp_o", int'(tstamp_o), e.ts);
                end
            end
        end
    end

    function automatic int pulse(int n, int st, int amp, int rise, int fall);
        if (n < st) return 0;
        if (n < st + rise) return amp * (n - st + 1) / rise;
        if (n < st + rise + fall) return amp * (st + rise + fall - n) / fall;
        return 0;
    endfunction

    task automatic clear_stim();
        for (int i = 0; i < MAXN; i++) begin
            xs[i] = 0; swv[i] = 0; exv[i] = 0;
        end
    endtask

    // expected values derived from R2, R3, R5-R10
    task automatic build_model(input int len);
        int la, lb, nw, bs, st, cnt, s, f, nst;
        bit ge, lz, ok, fire, trg;
        la = (c_avg > 5) ? 5 : int'(c_avg);
        lb = (c_span > 5) ? 5 : int'(c_span);
        nw = 1 << la;
        bs = 1 << lb;
        for (int u = 0; u <= len; u++) begin
            s = 0;
            for (int k = 0; k < nw; k++) if (u - k >= 1) s += xs[u-k];
            mm[u] = s >>> la;
            dd[u] = mm[u] - ((u - bs >= 0) ? mm[u-bs] : 0);
            ff[u] = c_order ? dd[u] - ((u - bs >= 0) ? dd[u-bs] : 0) : dd[u];
        end
        for (int n = 0; n <= len; n++) fexp[n] = (n >= 2) ? ff[n-2] : 0;
        st = 0; cnt = 0;
        for (int n = 1; n <= len; n++) begin
            f    = fexp[n-1];
            ge   = (f >= int'(c_thr));
            lz   = (f <= 0);
            ok   = !c_tot_en || (cnt >= int'(c_tot_min));
            fire = 1'b0;
            nst  = st;
            case (st)
                0: if (ge) begin nst = 1; cnt = 1; end
                1: begin
                    if (ge) cnt = (cnt < 255) ? cnt + 1 : 255;
                    else if (lz) begin fire = ok; nst = ok ? 3 : 0; end
                    else nst = ok ? 2 : 0;
                end
                2: if (lz) begin fire = 1'b1; nst = 3; end
                default: if (!ge) nst = 0;
            endcase
            st  = nst;
            trg = (fire && c_en[0]) || (swv[n] != 0 && c_en[1]) || (exv[n] != 0 && c_en[2]);
            if (trg) begin
                exp_t e;
                e.ed = n; e.ts = n - 1;
                q.push_back(e);
            end
        end
    endtask

    // driver: resets, pushes expected triggers, then streams the samples
    task automatic run_scn(input string ft, input string tt, input int len);
        rst_n = 1'b0; sample_i = '0; sw_trig = 1'b0; ext_trig = 1'b0;
        repeat (3) @(negedge clk);
        chk(trig_o == 1'b0, "R1", "trig_o in reset", int'(trig_o), 0);
        chk(tstamp_o == '0, "R1", "tstamp_o in reset", int'(tstamp_o), 0);
        chk(filt_o == '0, "R1", "filt_o in reset", int'(filt_o), 0);
        q.delete();
        build_model(len);
        ftag = ft; ttag = tt;
        rst_n = 1'b1;
        for (int n = 1; n <= len; n++) begin
            if (n > 1) @(negedge clk);
            sample_i = 14'(xs[n]);
            sw_trig  = (swv[n] != 0);
            ext_trig = (exv[n] != 0);
            if (n == 1) #1 mon_on = 1'b1;
        end
        @(negedge clk);
        #1 mon_on = 1'b0;
        chk(q.size() == 0, tt, "expected triggers left", q.size(), 0);
        q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R2 R3 R5 R6 R8 R9: first-order derivative, two pulses on a baseline
        clear_stim();
        for (int n = 1; n < 220; n++)
            xs[n] = 100 + pulse(n, 20, 2000, 4, 40) + pulse(n, 120, 1500, 3, 50);
        c_avg = 3'd2; c_span = 3'd2; c_order = 1'b0; c_thr = 16'sd300;
        c_tot_en = 1'b0; c_tot_min = 8'd0; c_en = 3'b001;
        run_scn("R2/R3", "R5/R6/R8", 220);

        // R3 R6: second-order derivative, negative baseline
        clear_stim();
        for (int n = 1; n < 220; n++) xs[n] = -500 + pulse(n, 30, 3000, 2, 60);
        c_avg = 3'd3; c_span = 3'd3; c_order = 1'b1; c_thr = 16'sd400;
        run_scn("R2/R3 CR2", "R6 CR2", 220);

        // R7: narrow pulse rejected by a long minimum
        clear_stim();
        for (int n = 1; n < 120; n++) xs[n] = pulse(n, 20, 1000, 3, 30);
        c_avg = 3'd0; c_span = 3'd1; c_order = 1'b0; c_thr = 16'sd200;
        c_tot_en = 1'b1; c_tot_min = 8'd20;
        run_scn("R3", "R7 reject", 120);

        // R7: same pulse accepted with a short minimum
        c_tot_min = 8'd2;
        run_scn("R3", "R7 accept", 120);

        // R10: self disabled, software and external requests enabled
        clear_stim();
        for (int n = 1; n < 200; n++) xs[n] = 100 + pulse(n, 20, 2000, 4, 40);
        swv[50] = 1; exv[90] = 1; swv[130] = 1; exv[130] = 1;
        c_avg = 3'd2; c_span = 3'd2; c_order = 1'b0; c_thr = 16'sd300;
        c_tot_en = 1'b0; c_en = 3'b110;
        run_scn("R3", "R10 ext/sw", 200);

        // R10: only the self-trigger enabled, requests ignored
        c_en = 3'b001;
        run_scn("R3", "R10 self only", 200);

        // R4: full-scale alternating input, shortest filter
        clear_stim();
        for (int n = 10; n < 80; n++) xs[n] = (n <= 40) ? ((n % 2) ? 8191 : -8192) : 8191;
        c_avg = 3'd0; c_span = 3'd0; c_order = 1'b1; c_thr = 16'sd32767;
        run_scn("R4", "R4", 80);

        // R2 R3: oversized settings clamp to the longest window and span
        clear_stim();
        for (int n = 1; n < 260; n++) xs[n] = 50 + pulse(n, 40, 4000, 6, 80);
        c_avg = 3'd7; c_span = 3'd6; c_order = 1'b0; c_thr = 16'sd200;
        run_scn("R2/R3 clamp", "R6 clamp", 260);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule